// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block keeps the bookkeeping for a ring of register windows: how many windows may still be saved into, how many hold restorable frames, how many belong to another context, and how many are known clean. It also holds the current window pointer and a six-bit trap-selection register. A core issues one window command per cycle (save, restore, flush, saved, restored). The block either applies the command to its counters and pointer, or it leaves them alone and reports a trap with a nine-bit trap type. The trap type is built from the selection register, and the choice of field depends on whether other-context windows exist.

The pointer is stored counting downward internally and is presented counting upward (reversed). Writes to the pointer accept any eight-bit value and reduce it into range. Each counter and the selection register can be loaded directly in any cycle without a command, so that trap handlers can restore context.

Top module: `regwin_ctl`

## Requirements
- R1: After reset, free windows is NWIN-2, restorable is 0, other is 0, clean is NWIN-1, the visible pointer is NWIN-1, the selection register is 0 and no trap is reported.
- R2: A save (cmd_op=1) with free windows at 0 reports a spill trap and changes nothing.
- R3: A save with nonzero free windows but clean equal to restorable (their difference is zero modulo 2^CW) reports trap type 0x024 and changes nothing.
- R4: Any other save decrements free windows, increments restorable and advances the visible pointer by one, wrapping from NWIN-1 to 0.
- R5: A restore (cmd_op=2) with restorable at 0 reports a fill trap. Any other restore increments free windows, decrements restorable and moves the visible pointer back by one, wrapping from 0 to NWIN-1.
- R6: The spill type is 0x080 and the fill type is 0x0C0, each ORed with a selection part. With other nonzero, that part is 0x020 plus selection bits 5:3 at bits 4:2. With other at zero, it is selection bits 2:0 at bits 4:2.
- R7: Flush (cmd_op=3) reports a spill trap unless free windows equals NWIN-2. It never changes state.
- R8: Saved (cmd_op=4) increments free windows. It then decrements restorable when other is 0, and decrements other otherwise.
- R9: Restored (cmd_op=5) increments restorable and raises clean by one only while clean is below NWIN-1. It then decrements free windows when other is 0, and decrements other otherwise.
- R10: The visible pointer equals NWIN-1 minus the internal pointer. Writing value v makes the visible pointer v mod NWIN.
- R11: trap_valid and trap_type appear one cycle after the command, as a one-cycle pulse. trap_type is 0 whenever trap_valid is low. A trapping command leaves all counters and the pointer unchanged. Counters are CW=$clog2(NWIN) bits wide and wrap modulo 2^CW.
- R12: Counter, pointer and selection writes (counter select 0 free, 1 restorable, 2 other, 3 clean) take effect one cycle later. They are ignored in any cycle with cmd_valid high, and cmd_op values 0, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Window command present |
| cmd_op | input | 3 | Command code (1 save, 2 restore, 3 flush, 4 saved, 5 restored) |
| sel_we | input | 1 | Load selection register |
| sel_wd | input | 6 | Selection register value |
| cnt_we | input | 1 | Load one counter |
| cnt_sel | input | 2 | Counter to load |
| cnt_wd | input | CW | Counter value |
| ptr_we | input | 1 | Load window pointer (visible numbering) |
| ptr_wd | input | IW | Pointer value, reduced modulo NWIN |
| trap_valid | output | 1 | Trap pulse |
| trap_type | output | 9 | Trap type code |
| free_cnt | output | CW | Windows available to save |
| rest_cnt | output | CW | Windows available to restore |
| other_cnt | output | CW | Windows of another context |
| clean_cnt | output | CW | Clean windows |
| sel_q | output | 6 | Selection register |
| ptr_vis | output | CW | Visible window pointer |

## Verification
The bench builds the block with NWIN=5, which is not a power of two, so the modulo pointer wrap and the reduction of written pointer values are both exercised, while CW=3 keeps the counter space at eight codes. With five windows, every combination of the four counters in 0..4 is crossed with all five commands. Each combination starts from a fresh pointer and selection value. This covers every trap condition, both selection-field paths, the clean saturation and the counter wrap. All 256 pointer write values are swept separately.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam logic [2:0] OP_SAVE     = 3'd1;
  localparam logic [2:0] OP_RESTORE  = 3'd2;
  localparam logic [2:0] OP_FLUSH    = 3'd3;
  localparam logic [2:0] OP_SAVED    = 3'd4;
  localparam logic [2:0] OP_RESTORED = 3'd5;

  localparam logic [8:0] TT_SPILL_BASE = 9'h080;
  localparam logic [8:0] TT_FILL_BASE  = 9'h0C0;
  localparam logic [8:0] TT_OTHER_FLAG = 9'h020;
  localparam logic [8:0] TT_CLEAN      = 9'h024;

  // Compose a spill/fill trap type from a base and the selection register.
  function automatic logic [8:0] trap_code(input logic [8:0] base,
                                           input logic other_nz,
                                           input logic [5:0] sel);
    logic [8:0] low;
    if (other_nz) low = TT_OTHER_FLAG | {4'b0, sel[5:3], 2'b00};
    else          low = {4'b0, sel[2:0], 2'b00};
    return base | low;
  endfunction
endpackage

// File: rtl/regwin_trapenc.sv
module regwin_trapenc
  import regwin_pkg::*;
(
  input  logic       other_nz,
  input  logic [5:0] sel,
  output logic [8:0] spill_tt,
  output logic [8:0] fill_tt
);
  assign spill_tt = trap_code(TT_SPILL_BASE, other_nz, sel);
  assign fill_tt  = trap_code(TT_FILL_BASE,  other_nz, sel);
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int NWIN = 8,
  parameter int IW   = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_dn,
  input  logic          step_up,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_data,
  output logic [CW-1:0] vis
);
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  logic [CW-1:0] ptr_q;
  logic [IW-1:0] wr_mod;

  assign wr_mod = wr_data % IW'(NWIN);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (wr_en)   ptr_q <= TOP - CW'(wr_mod);
    else if (step_dn) ptr_q <= (ptr_q == '0) ? TOP : ptr_q - CW'(1);
    else if (step_up) ptr_q <= (ptr_q == TOP) ? '0 : ptr_q + CW'(1);
  end

  assign vis = TOP - ptr_q;

  // R10
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= TOP);

  // R4
  ptr_down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !wr_en && ptr_q == '0) |=> ptr_q == TOP);

  // R5
  ptr_up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !step_dn && !wr_en && ptr_q == TOP) |=> ptr_q == '0);
endmodule

// File: rtl/regwin_ctr.sv
module regwin_ctr #(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_save,
  input  logic          ev_restore,
  input  logic          ev_saved,
  input  logic          ev_restored,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] free_q,
  output logic [CW-1:0] rest_q,
  output logic [CW-1:0] other_q,
  output logic [CW-1:0] clean_q
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  logic [CW-1:0] free_n, rest_n, other_n, clean_n;

  always_comb begin
    free_n  = free_q;
    rest_n  = rest_q;
    other_n = other_q;
    clean_n = clean_q;
    if (wr_en) begin
      case (wr_sel)
        2'd0:    free_n  = wr_data;
        2'd1:    rest_n  = wr_data;
        2'd2:    other_n = wr_data;
        default: clean_n = wr_data;
      endcase
    end else if (ev_save) begin
      free_n = free_q - ONE;
      rest_n = rest_q + ONE;
    end else if (ev_restore) begin
      free_n = free_q + ONE;
      rest_n = rest_q - ONE;
    end else if (ev_saved) begin
      free_n = free_q + ONE;
      if (other_q == '0) rest_n  = rest_q - ONE;
      else               other_n = other_q - ONE;
    end else if (ev_restored) begin
      rest_n = rest_q + ONE;
      if (clean_q < TOP) clean_n = clean_q + ONE;
      if (other_q == '0) free_n  = free_q - ONE;
      else               other_n = other_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q  <= CW'(NWIN - 2);
      rest_q  <= '0;
      other_q <= '0;
      clean_q <= TOP;
    end else begin
      free_q  <= free_n;
      rest_q  <= rest_n;
      other_q <= other_n;
      clean_q <= clean_n;
    end
  end

  // R4
  save_moves_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_save && !wr_en) |=> free_q == $past(free_q) - ONE);

  // R8
  saved_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_saved && !wr_en && !ev_save && !ev_restore && other_q != '0) |=> $stable(rest_q));

  // R9
  clean_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_restored && !wr_en && !ev_save && !ev_restore && !ev_saved && clean_q >= TOP)
      |=> $stable(clean_q));
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int IW   = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          sel_we,
  input  logic [5:0]    sel_wd,
  input  logic          cnt_we,
  input  logic [1:0]    cnt_sel,
  input  logic [CW-1:0] cnt_wd,
  input  logic          ptr_we,
  input  logic [IW-1:0] ptr_wd,
  output logic          trap_valid,
  output logic [8:0]    trap_type,
  output logic [CW-1:0] free_cnt,
  output logic [CW-1:0] rest_cnt,
  output logic [CW-1:0] other_cnt,
  output logic [CW-1:0] clean_cnt,
  output logic [5:0]    sel_q,
  output logic [CW-1:0] ptr_vis
);
  localparam logic [CW-1:0] FLUSH_OK = CW'(NWIN - 2);

  logic is_save, is_rest, is_flush, is_saved, is_restored;
  logic save_spill, save_clean, rest_fill, flush_spill;
  logic ev_save_ok, ev_rest_ok, ev_trap;
  logic [CW-1:0] clean_gap;
  logic [8:0] spill_tt, fill_tt, tt_nxt;

  assign is_save     = cmd_valid && cmd_op == OP_SAVE;
  assign is_rest     = cmd_valid && cmd_op == OP_RESTORE;
  assign is_flush    = cmd_valid && cmd_op == OP_FLUSH;
  assign is_saved    = cmd_valid && cmd_op == OP_SAVED;
  assign is_restored = cmd_valid && cmd_op == OP_RESTORED;

  assign clean_gap   = clean_cnt - rest_cnt;
  assign save_spill  = is_save && free_cnt == '0;
  assign save_clean  = is_save && free_cnt != '0 && clean_gap == '0;
  assign ev_save_ok  = is_save && !save_spill && !save_clean;
  assign rest_fill   = is_rest && rest_cnt == '0;
  assign ev_rest_ok  = is_rest && !rest_fill;
  assign flush_spill = is_flush && free_cnt != FLUSH_OK;
  assign ev_trap     = save_spill || save_clean || rest_fill || flush_spill;

  regwin_trapenc u_enc (
    .other_nz (other_cnt != '0),
    .sel      (sel_q),
    .spill_tt (spill_tt),
    .fill_tt  (fill_tt)
  );

  always_comb begin
    if (save_clean)     tt_nxt = TT_CLEAN;
    else if (rest_fill) tt_nxt = fill_tt;
    else                tt_nxt = spill_tt;
  end

  regwin_ctr #(.NWIN(NWIN)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_save     (ev_save_ok),
    .ev_restore  (ev_rest_ok),
    .ev_saved    (is_saved),
    .ev_restored (is_restored),
    .wr_en       (cnt_we && !cmd_valid),
    .wr_sel      (cnt_sel),
    .wr_data     (cnt_wd),
    .free_q      (free_cnt),
    .rest_q      (rest_cnt),
    .other_q     (other_cnt),
    .clean_q     (clean_cnt)
  );

  regwin_ptr #(.NWIN(NWIN), .IW(IW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_dn (ev_save_ok),
    .step_up (ev_rest_ok),
    .wr_en   (ptr_we && !cmd_valid),
    .wr_data (ptr_wd),
    .vis     (ptr_vis)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_type  <= '0;
      sel_q      <= '0;
    end else begin
      trap_valid <= ev_trap;
      trap_type  <= ev_trap ? tt_nxt : 9'h000;
      if (sel_we && !cmd_valid) sel_q <= sel_wd;
    end
  end

  // R11
  trap_freezes_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> ($stable(free_cnt) && $stable(rest_cnt) && $stable(ptr_vis)));

  // R6
  trap_code_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_type[8] == 1'b0 && trap_type[1:0] == 2'b00));

  // R4
  save_advances_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_save_ok |=> ptr_vis == (($past(ptr_vis) == CW'(NWIN - 1)) ? '0 : $past(ptr_vis) + CW'(1)));

  // R12
  write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd0 || cmd_op > OP_RESTORED)) |=>
      ($stable(free_cnt) && $stable(rest_cnt) && $stable(other_cnt) &&
       $stable(clean_cnt) && $stable(sel_q) && $stable(ptr_vis)));
endmodule

// File: tb/regwin_ctl_tb.sv
`timescale 1ns/100ps
module regwin_ctl_tb_top;
  localparam int NWIN = 5;
  localparam int IW   = 8;
  localparam int CW   = $clog2(NWIN);
  localparam int MSK  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic sel_we = 1'b0;
  logic [5:0] sel_wd = '0;
  logic cnt_we = 1'b0;
  logic [1:0] cnt_sel = '0;
  logic [CW-1:0] cnt_wd = '0;
  logic ptr_we = 1'b0;
  logic [IW-1:0] ptr_wd = '0;
  logic trap_valid;
  logic [8:0] trap_type;
  logic [CW-1:0] free_cnt, rest_cnt, other_cnt, clean_cnt, ptr_vis;
  logic [5:0] sel_q;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  regwin_ctl #(.NWIN(NWIN), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .sel_we(sel_we), .sel_wd(sel_wd), .cnt_we(cnt_we), .cnt_sel(cnt_sel),
    .cnt_wd(cnt_wd), .ptr_we(ptr_we), .ptr_wd(ptr_wd),
    .trap_valid(trap_valid), .trap_type(trap_type), .free_cnt(free_cnt),
    .rest_cnt(rest_cnt), .other_cnt(other_cnt), .clean_cnt(clean_cnt),
    .sel_q(sel_q), .ptr_vis(ptr_vis)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int tt_of(input int base, input int ow, input int ws);
    if (ow != 0) return base | 32 | (((ws >> 3) & 7) << 2);
    return base | ((ws & 7) << 2);
  endfunction

  task automatic wr_cnt(input int s, input int v);
    cnt_we = 1'b1; cnt_sel = 2'(s); cnt_wd = CW'(v);
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic run_cmd(input int op);
    cmd_valid = 1'b1; cmd_op = 3'(op);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 free", int'(free_cnt), NWIN - 2);
    chk("R1 rest", int'(rest_cnt), 0);
    chk("R1 other", int'(other_cnt), 0);
    chk("R1 clean", int'(clean_cnt), NWIN - 1);
    chk("R1 ptr", int'(ptr_vis), NWIN - 1);
    chk("R1 sel", int'(sel_q), 0);
    chk("R1 trap", int'(trap_valid), 0);

    // R10 pointer write sweep
    for (int v = 0; v < 256; v++) begin
      ptr_we = 1'b1; ptr_wd = 8'(v);
      @(negedge clk);
      ptr_we = 1'b0;
      chk("R10 ptr write", int'(ptr_vis), v % NWIN);
    end

    // R12 writes ignored during a command (op 0, 6, 7 do nothing)
    for (int op = 0; op < 8; op += 1) begin
      if (op >= 1 && op <= 5) continue;
      cnt_we = 1'b1; cnt_sel = 2'd0; cnt_wd = CW'(1);
      sel_we = 1'b1; sel_wd = 6'h2A;
      ptr_we = 1'b1; ptr_wd = 8'd2;
      cmd_valid = 1'b1; cmd_op = 3'(op);
      @(negedge clk);
      cnt_we = 1'b0; sel_we = 1'b0; ptr_we = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
      chk("R12 free held", int'(free_cnt), NWIN - 2);
      chk("R12 sel held", int'(sel_q), 0);
      chk("R12 ptr held", int'(ptr_vis), 255 % NWIN);
      chk("R12 no trap", int'(trap_valid), 0);
    end

    // Exhaustive command sweep
    for (int cs = 0; cs < NWIN; cs++)
    for (int cr = 0; cr < NWIN; cr++)
    for (int ow = 0; ow < NWIN; ow++)
    for (int cw = 0; cw < NWIN; cw++)
    for (int op = 1; op <= 5; op++) begin
      int ws, pv, ecs, ecr, eow, ecw, ept, etv, ett;
      string tag;
      ws = (idx * 13 + 5) % 64;
      pv = (idx * 7) % 256;
      idx++;
      wr_cnt(0, cs); wr_cnt(1, cr); wr_cnt(2, ow); wr_cnt(3, cw);
      sel_we = 1'b1; sel_wd = 6'(ws); ptr_we = 1'b1; ptr_wd = 8'(pv);
      @(negedge clk);
      sel_we = 1'b0; ptr_we = 1'b0;
      ecs = cs; ecr = cr; eow = ow; ecw = cw; ept = pv % NWIN; etv = 0; ett = 0;
      case (op)
        1: begin
          tag = "R2 R3 R4 save";
          if (cs == 0) begin etv = 1; ett = tt_of(128, ow, ws); end
          else if (((cw - cr) & MSK) == 0) begin etv = 1; ett = 36; end
          else begin ecs = (cs - 1) & MSK; ecr = (cr + 1) & MSK; ept = (ept + 1) % NWIN; end
        end
        2: begin
          tag = "R5 R6 restore";
          if (cr == 0) begin etv = 1; ett = tt_of(192, ow, ws); end
          else begin ecs = (cs + 1) & MSK; ecr = (cr - 1) & MSK; ept = (ept + NWIN - 1) % NWIN; end
        end
        3: begin
          tag = "R7 flush";
          if (cs != NWIN - 2) begin etv = 1; ett = tt_of(128, ow, ws); end
        end
        4: begin
          tag = "R8 saved";
          ecs = (cs + 1) & MSK;
          if (ow == 0) ecr = (cr - 1) & MSK; else eow = (ow - 1) & MSK;
        end
        default: begin
          tag = "R9 restored";
          ecr = (cr + 1) & MSK;
          if (cw < NWIN - 1) ecw = cw + 1;
          if (ow == 0) ecs = (cs - 1) & MSK; else eow = (ow - 1) & MSK;
        end
      endcase
      run_cmd(op);
      // R11 trap pulse and state
      chk({tag, " R11 trap_valid"}, int'(trap_valid), etv);
      chk({tag, " R6 trap_type"}, int'(trap_type), ett);
      chk({tag, " free"}, int'(free_cnt), ecs);
      chk({tag, " rest"}, int'(rest_cnt), ecr);
      chk({tag, " other"}, int'(other_cnt), eow);
      chk({tag, " clean"}, int'(clean_cnt), ecw);
      chk({tag, " R10 ptr"}, int'(ptr_vis), ept);
      @(negedge clk);
      chk("R11 pulse ends", int'(trap_valid), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule